// File: doc/BRIEF.md
# Virtual Partition ID Mapping Table

This block translates a small virtual partition identifier into a 16-bit physical partition identifier. Software fills a bank of 64-bit mapping words through a simple indexed register port. Each word carries four 16-bit physical IDs, so a bank of up to eight words covers virtual IDs 0 to 31. A separate 32-bit validity vector marks which of those entries may be used.

Each translation request carries a 5-bit virtual ID and a flag naming the privilege context it came from: the upper (kernel) level or the lower (user) level. Translation is applied only when the hypervisor level is active and the enable for that request's context is set. Otherwise the ID passes through unchanged, zero-extended to 16 bits. The parameter `MAX_IDX` sets the highest implemented word index. Accesses above it are refused and flagged, and virtual IDs that fall beyond the implemented words translate to nothing.

Top module: `vpart_map`

## Requirements
- R1: After reset, every mapping word reads as zero, the validity vector is all zeros, and `rsp_vld`, `rsp_id`, `rd_data` and `acc_err` are zero.
- R2: A write with `wr_en` stores all 64 bits of `wr_data` into word `reg_idx`. A read with `rd_en` returns that word on `rd_data` one cycle later.
- R3: Virtual ID k maps to word k/4, bits [16*(k%4)+15 : 16*(k%4)]. For example, ID 7 is bits [63:48] of word 1 and ID 4 is bits [15:0] of word 1.
- R4: A translated lookup of ID n whose bit n in the validity vector is 0 returns `rsp_id` = 0 with `rsp_vld` = 0. `rsp_id` is zero whenever `rsp_vld` is low.
- R5: A request with `req_upper`=1 is translated only when `en_upper`=1. Otherwise it passes through with `rsp_id` = zero-extended ID and `rsp_vld` = 1.
- R6: A request with `req_upper`=0 is translated only when `en_lower`=1, independently of `en_upper`. Otherwise it passes through.
- R7: When `hyp_en`=0, every request passes through unchanged with `rsp_vld`=1, whatever the enables are.
- R8: A read or write with `reg_idx` > `MAX_IDX` changes no word. Such a read returns 0, and `acc_err` is 1 in the cycle after the access. `acc_err` is 0 after an in-range access.
- R9: A translated lookup of an ID above 4*(MAX_IDX+1)-1 returns `rsp_id` = 0 with `rsp_vld` = 0, even if its validity bit is set.
- R10: A response appears exactly one cycle after its request. A lookup issued in the cycle after a write sees the written value.
- R11: `vld_we` loads all 32 bits of `vld_wdata` into the validity vector. Bit n gates virtual ID n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mapping word write strobe |
| rd_en | input | 1 | Mapping word read strobe |
| reg_idx | input | 3 | Word index for read or write |
| wr_data | input | 64 | Write data, four packed 16-bit IDs |
| rd_data | output | 64 | Read data, valid one cycle after rd_en |
| acc_err | output | 1 | Out-of-range index on the previous access |
| vld_we | input | 1 | Validity vector write strobe |
| vld_wdata | input | 32 | New validity vector |
| hyp_en | input | 1 | Hypervisor level active in the current security state |
| en_upper | input | 1 | Translation enable for upper-level requests |
| en_lower | input | 1 | Translation enable for lower-level requests |
| req_vld | input | 1 | Translation request strobe |
| req_id | input | 5 | Virtual partition ID |
| req_upper | input | 1 | 1 when the request comes from the upper level, 0 for the lower level |
| rsp_vld | output | 1 | Translated or passed-through ID is valid |
| rsp_id | output | 16 | Physical partition ID |

## Verification
A corrupted mapping word or validity bit shows up at the ports one cycle after a lookup of any ID that uses it: `rsp_id` comes back wrong, or `rsp_vld` drops. The same corruption is visible one cycle after a read of that word. A wrong lane selection swaps IDs inside a word, so the bench writes a distinct value into every lane and looks up each one. An out-of-range write that wrongly lands in storage would surface on the next read of the surviving words, so those words are read back after every refused access.

// File: rtl/vpart_map.sv
module vpart_map #(
  parameter int MAX_IDX = 7,
  parameter int PID_W   = 16,
  parameter int VID_W   = 5,
  parameter int IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [4*PID_W-1:0]   wr_data,
  output logic [4*PID_W-1:0]   rd_data,
  output logic                 acc_err,
  input  logic                 vld_we,
  input  logic [(1<<VID_W)-1:0] vld_wdata,
  input  logic                 hyp_en,
  input  logic                 en_upper,
  input  logic                 en_lower,
  input  logic                 req_vld,
  input  logic [VID_W-1:0]     req_id,
  input  logic                 req_upper,
  output logic                 rsp_vld,
  output logic [PID_W-1:0]     rsp_id
);
  localparam int NREG   = MAX_IDX + 1;
  localparam int NENT   = 4 * NREG;
  localparam int WORD_W = 4 * PID_W;
  localparam int NVEC   = 1 << VID_W;

  logic [WORD_W-1:0] map_q [NREG];
  logic [NVEC-1:0]   vld_q;

  wire idx_ok    = int'(reg_idx) <= MAX_IDX;
  wire in_range  = int'(req_id) < NENT;
  wire translate = hyp_en && (req_upper ? en_upper : en_lower);
  wire [IDX_W-1:0] sel_reg  = IDX_W'(req_id >> 2);
  wire [1:0]       sel_lane = req_id[1:0];

  logic [WORD_W-1:0] sel_word;
  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(sel_reg) == i) sel_word = map_q[i];
  end

  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(reg_idx) == i) rd_word = map_q[i];
  end

  wire [PID_W-1:0] entry = sel_word[sel_lane*PID_W +: PID_W];
  wire             hit   = in_range && vld_q[req_id];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                  map_q[g] <= '0;
      else if (wr_en && int'(reg_idx) == g)        map_q[g] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      vld_q <= '0;
    else if (vld_we) vld_q <= vld_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data <= '0;
      acc_err <= 1'b0;
    end else begin
      rd_data <= (rd_en && idx_ok) ? rd_word : '0;
      acc_err <= (wr_en || rd_en) && !idx_ok;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      rsp_id  <= '0;
    end else if (!req_vld) begin
      rsp_vld <= 1'b0;
      rsp_id  <= '0;
    end else if (!translate) begin
      rsp_vld <= 1'b1;
      rsp_id  <= PID_W'(req_id);
    end else begin
      rsp_vld <= hit;
      rsp_id  <= hit ? entry : '0;
    end

  a_r4_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> rsp_id == '0);

  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && !hyp_en |=> rsp_vld && rsp_id == PID_W'($past(req_id)));

  a_r8_bad_index_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !idx_ok |=> acc_err && rd_data == '0);

  a_r9_beyond_table: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && translate && !in_range |=> !rsp_vld);

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(req_vld));
endmodule

// File: tb/tb_vpart_map.sv
module tb_vpart_map;
  localparam int MAXI = 5;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, vld_we = 0, hyp_en = 0, en_upper = 0, en_lower = 0;
  logic req_vld = 0, req_upper = 0;
  logic [2:0] reg_idx = 0;
  logic [63:0] wr_data = 0, rd_data;
  logic [31:0] vld_wdata = 0;
  logic [4:0] req_id = 0;
  logic acc_err, rsp_vld;
  logic [15:0] rsp_id;

  vpart_map #(.MAX_IDX(MAXI)) dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [63:0] mdl [8];
  logic [31:0] vv = 0;
  typedef struct { logic vld; logic [15:0] id; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [4:0] id, logic up, string tag);
    exp_t e; e.tag = tag;
    if (!(hyp_en && (up ? en_upper : en_lower))) begin e.vld = 1; e.id = 16'(id); end
    else if (int'(id) < 4*(MAXI+1) && vv[id]) begin e.vld = 1; e.id = mdl[id/4][16*(id%4) +: 16]; end
    else begin e.vld = 0; e.id = 0; end
    return e;
  endfunction

  task automatic wr(int idx, logic [63:0] d, logic bad, string tag);
    wr_en = 1; reg_idx = 3'(idx); wr_data = d;
    if (idx <= MAXI) mdl[idx] = d;
    @(posedge clk); #2;
    chk({tag, " acc_err"}, 64'(acc_err), 64'(bad));
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int idx, logic bad, string tag);
    logic [63:0] e;
    e = (idx <= MAXI) ? mdl[idx] : 64'd0;
    rd_en = 1; reg_idx = 3'(idx);
    @(posedge clk); #2;
    chk({tag, " rd_data"}, rd_data, e);
    chk({tag, " acc_err"}, 64'(acc_err), 64'(bad));
    @(negedge clk); rd_en = 0;
  endtask

  task automatic setv(logic [31:0] v);
    vld_we = 1; vld_wdata = v; vv = v;
    @(negedge clk); vld_we = 0;
  endtask

  task automatic look(logic [4:0] id, logic up, string tag);
    req_vld = 1; req_id = id; req_upper = up;
    q.push_back(model(id, up, tag));
    @(negedge clk); req_vld = 0;
  endtask

  always @(posedge clk) begin
    logic was;
    was = req_vld;
    #2;
    if (was && rst_n) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " rsp_vld"}, 64'(rsp_vld), 64'(e.vld));
      chk({e.tag, " rsp_id"}, 64'(rsp_id), 64'(e.id));
    end
  end

  initial begin
    #(8*200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_vld", 64'(rsp_vld), 0);
    chk("R1 rsp_id", 64'(rsp_id), 0);
    chk("R1 acc_err", 64'(acc_err), 0);
    rd(0, 0, "R1 word0");
    rd(5, 0, "R1 word5");
    hyp_en = 1; en_upper = 1; en_lower = 1;
    look(5'd3, 1, "R1 R4 empty vector");

    for (int i = 0; i <= MAXI; i++) begin
      logic [63:0] d;
      d = {16'(i*4+3) | 16'hA000, 16'(i*4+2) | 16'hB000, 16'(i*4+1) | 16'hC000, 16'(i*4) | 16'hD000};
      wr(i, d, 0, "R2 write");
    end
    rd(1, 0, "R2 word1");
    rd(4, 0, "R2 word4");
    setv(32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) look(5'(k), 1, "R3 R11 lane");
    look(5'd23, 0, "R3 last lane");
    setv(32'hFFFF_FFBF);
    look(5'd6, 1, "R4 cleared bit");
    look(5'd7, 1, "R4 neighbour kept");
    look(5'd24, 1, "R9 beyond table");
    look(5'd31, 0, "R9 top id");

    en_upper = 0;
    look(5'd5, 1, "R5 upper off passthrough");
    look(5'd5, 0, "R6 lower still on");
    en_upper = 1; en_lower = 0;
    look(5'd9, 0, "R6 lower off passthrough");
    look(5'd9, 1, "R5 upper on");
    en_lower = 1; hyp_en = 0;
    look(5'd6, 1, "R7 hyp off upper");
    look(5'd30, 0, "R7 hyp off lower");
    hyp_en = 1;

    wr(6, 64'hDEAD_BEEF_0000_1111, 1, "R8 bad write");
    rd(7, 1, "R8 bad read");
    rd(1, 0, "R8 word1 intact");
    rd(5, 0, "R8 word5 intact");

    wr(2, 64'h1234_5678_9ABC_DEF0, 0, "R10 write");
    look(5'd9, 1, "R10 lookup next cycle");
    look(5'd11, 0, "R10 top lane");

    repeat (3) @(negedge clk);
    chk("R10 queue drained", 64'(q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule